// File: doc/BRIEF.md
# SDRAM Bank Access Statistics Monitor

This block watches the access strobes of a four-bank SDRAM controller and counts, for every video frame, how many accesses each bank served. Each count is kept three ways: over the whole frame, over the visible part of the frame, and over the blanking interval. A one-cycle frame-start strobe closes the frame. The running counts are then copied into snapshot registers and the counters start again from zero.

A 6-bit view address picks one 8-bit figure from the snapshots for display. The figure is either one bank or the sum over all banks, in one of three regions, at a coarse or a fine scale. The result is a plain binary byte and is mainly useful for comparing how evenly the banks are loaded. The readout path is combinational from the snapshot registers, so a new address shows its figure in the same cycle.

Top module: `sdram_stat_mon`

## Requirements
- R1: After reset every snapshot is zero, so `viewData` is 0 for every `viewAddr` value until the first frame-start strobe.
- R2: When `viewAddr[5]` is 0, `viewAddr[1:0]` selects the bank (0 to 3) whose snapshot is shown.
- R3: When `viewAddr[5]` is 1, the value shown is the sum of the selected snapshot over all four banks.
- R4: `viewAddr[4]` sets the scale. When it is 0, `viewData` is bits 19:12 of the selected count, which is the count divided by 4096 with the quotient truncated to 8 bits. When it is 1, `viewData` is bits 15:8 of the count, which is the count divided by 256 with the quotient truncated to 8 bits. Higher bits are dropped, so this view wraps.
- R5: `viewAddr[3:2]` selects the region. The encodings are 0 for the whole frame, 1 for the active area (`inBlank` low) and 2 for the blanking area (`inBlank` high). An encoding of 3 shows 0.
- R6: On a cycle with `frameStart` high, each snapshot takes the count accumulated since the previous strobe and the live counter restarts. An access in that same cycle counts as the first access of the new frame. Between strobes the snapshots, and therefore `viewData` for a fixed address, do not change.
- R7: Each per-bank counter is CNT_W bits wide (20 by default). At its all-ones value it holds instead of wrapping.
- R8: An access in a cycle is counted as active or as blank according to `inBlank` in that cycle, and never as both. The whole-frame count of a bank equals its active count plus its blank count whenever the whole-frame count is not saturated.
- R9: Values are plain binary and are not BCD coded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bankAccess | input | 4 | One strobe per bank; bit n high counts one access to bank n this cycle |
| inBlank | input | 1 | High while the video timing is in blanking |
| frameStart | input | 1 | One-cycle pulse marking the start of a new frame |
| viewAddr | input | 6 | Selects bank or sum, scale and region of the figure shown |
| viewData | output | 8 | Selected statistic, plain binary |

## Verification
Every test reads all 64 view addresses and compares each one against a model of the requirements, so the bank, sum, scale and region decodes are exercised together. The first pattern places a different mix of accesses in active and blank time on each bank, so that any swapped bank, swapped region or wrong shift produces a different byte. A second pattern places accesses on the frame-start cycle itself and reads the snapshots mid-frame, which separates counting on the boundary from missing it and catches a snapshot that moves between strobes. A long run drives two banks past the counter limit, which shows whether the counters saturate and whether the fine view wraps on the four-bank sum. An empty frame afterwards shows that the live counters are cleared.

// File: rtl/sdram_stat_pkg.sv
package sdram_stat_pkg;
  localparam int NUM_BANKS    = 4;
  localparam int BANK_SEL_W   = $clog2(NUM_BANKS);
  localparam int ADDR_W       = 6;
  localparam int VIEW_W       = 8;
  localparam int FINE_SHIFT   = 8;
  localparam int COARSE_SHIFT = 12;

  typedef enum logic [1:0] {
    REG_FRAME  = 2'd0,
    REG_ACTIVE = 2'd1,
    REG_BLANK  = 2'd2,
    REG_NONE   = 2'd3
  } region_e;

  typedef struct packed {
    logic                 restart;
    logic [NUM_BANKS-1:0] incActive;
    logic [NUM_BANKS-1:0] incBlank;
  } ctrl_strobes_t;
endpackage

// File: rtl/sdram_stat_ctrl.sv
module sdram_stat_ctrl
  import sdram_stat_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_BANKS-1:0] bankAccess,
  input  logic                 inBlank,
  input  logic                 frameStart,
  output ctrl_strobes_t        strobes
);
  always_comb begin
    strobes.restart   = frameStart;
    strobes.incActive = bankAccess & {NUM_BANKS{~inBlank}};
    strobes.incBlank  = bankAccess & {NUM_BANKS{inBlank}};
  end

  // an access goes to exactly one region
  assert_region_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    (strobes.incActive & strobes.incBlank) == '0);
  assert_access_kept_R8: assert property (@(posedge clk) disable iff (rst)
    (strobes.incActive | strobes.incBlank) == bankAccess);
endmodule

// File: rtl/sdram_stat_counter.sv
module sdram_stat_counter #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             inc,
  output logic [CNT_W-1:0] liveCount,
  output logic [CNT_W-1:0] snapCount
);
  localparam logic [CNT_W-1:0] MAX_COUNT = '1;
  localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      liveCount <= '0;
      snapCount <= '0;
    end else if (restart) begin
      snapCount <= liveCount;
      liveCount <= inc ? ONE : '0;
    end else if (inc && liveCount != MAX_COUNT) begin
      liveCount <= liveCount + ONE;
    end
  end

  assert_saturate_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!restart && liveCount == MAX_COUNT) |=> liveCount == MAX_COUNT);
  assert_snapshot_take_R6: assert property (@(posedge clk) disable iff (rst)
    restart |=> snapCount == $past(liveCount));
  assert_snapshot_stable_R6: assert property (@(posedge clk) disable iff (rst)
    !restart |=> $stable(snapCount));
  assert_restart_first_R6: assert property (@(posedge clk) disable iff (rst)
    (restart && inc) |=> liveCount == ONE);
  assert_restart_empty_R6: assert property (@(posedge clk) disable iff (rst)
    (restart && !inc) |=> liveCount == '0);
endmodule

// File: rtl/sdram_stat_datapath.sv
module sdram_stat_datapath
  import sdram_stat_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_strobes_t     strobes,
  input  logic [ADDR_W-1:0] viewAddr,
  output logic [VIEW_W-1:0] viewData
);
  localparam int SUM_W = CNT_W + BANK_SEL_W;
  localparam logic [CNT_W-1:0] MAX_COUNT = '1;

  logic [CNT_W-1:0] liveFrm [NUM_BANKS];
  logic [CNT_W-1:0] liveAct [NUM_BANKS];
  logic [CNT_W-1:0] liveBlk [NUM_BANKS];
  logic [CNT_W-1:0] snapFrm [NUM_BANKS];
  logic [CNT_W-1:0] snapAct [NUM_BANKS];
  logic [CNT_W-1:0] snapBlk [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    sdram_stat_counter #(.CNT_W(CNT_W)) frameCnt (
      .clk(clk), .rst(rst), .restart(strobes.restart),
      .inc(strobes.incActive[b] | strobes.incBlank[b]),
      .liveCount(liveFrm[b]), .snapCount(snapFrm[b]));
    sdram_stat_counter #(.CNT_W(CNT_W)) activeCnt (
      .clk(clk), .rst(rst), .restart(strobes.restart),
      .inc(strobes.incActive[b]),
      .liveCount(liveAct[b]), .snapCount(snapAct[b]));
    sdram_stat_counter #(.CNT_W(CNT_W)) blankCnt (
      .clk(clk), .rst(rst), .restart(strobes.restart),
      .inc(strobes.incBlank[b]),
      .liveCount(liveBlk[b]), .snapCount(snapBlk[b]));

    assert_frame_split_R8: assert property (@(posedge clk) disable iff (rst)
      (liveFrm[b] != MAX_COUNT) |->
        ({1'b0, liveFrm[b]} == {1'b0, liveAct[b]} + {1'b0, liveBlk[b]}));
  end

  region_e          regionSel;
  logic [SUM_W-1:0] perBank [NUM_BANKS];
  logic [SUM_W-1:0] bankTotal;
  logic [SUM_W-1:0] chosen;
  logic [SUM_W-1:0] scaled;

  always_comb begin
    regionSel = region_e'(viewAddr[3:2]);
    bankTotal = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      unique case (regionSel)
        REG_FRAME:  perBank[b] = SUM_W'(snapFrm[b]);
        REG_ACTIVE: perBank[b] = SUM_W'(snapAct[b]);
        REG_BLANK:  perBank[b] = SUM_W'(snapBlk[b]);
        default:    perBank[b] = '0;
      endcase
      bankTotal = bankTotal + perBank[b];
    end
    chosen   = viewAddr[5] ? bankTotal : perBank[viewAddr[BANK_SEL_W-1:0]];
    scaled   = viewAddr[4] ? (chosen >> FINE_SHIFT) : (chosen >> COARSE_SHIFT);
    viewData = scaled[VIEW_W-1:0];
  end
endmodule

// File: rtl/sdram_stat_mon.sv
module sdram_stat_mon
  import sdram_stat_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] bankAccess,
  input  logic       inBlank,
  input  logic       frameStart,
  input  logic [5:0] viewAddr,
  output logic [7:0] viewData
);
  ctrl_strobes_t strobes;

  sdram_stat_ctrl ctrl (
    .clk(clk), .rst(rst), .bankAccess(bankAccess), .inBlank(inBlank),
    .frameStart(frameStart), .strobes(strobes));

  sdram_stat_datapath #(.CNT_W(CNT_W)) datapath (
    .clk(clk), .rst(rst), .strobes(strobes), .viewAddr(viewAddr),
    .viewData(viewData));

  assert_unused_region_R5: assert property (@(posedge clk) disable iff (rst)
    (viewAddr[3:2] == 2'b11) |-> viewData == 8'h00);
endmodule

// File: tb/sdram_stat_mon_test.sv
module sdram_stat_mon_test;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 16;
  localparam int MAXC       = (1 << CNT_W) - 1;
  localparam int WATCHDOG   = 200000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] bankAccess = '0;
  logic       inBlank = 1'b0;
  logic       frameStart = 1'b0;
  logic [5:0] viewAddr = '0;
  logic [7:0] viewData;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 1'b0;

  // reference model of the requirements
  int liveAct [4];
  int liveBlk [4];
  int liveFrm [4];
  int snapAct [4];
  int snapBlk [4];
  int snapFrm [4];

  sdram_stat_mon #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .bankAccess(bankAccess), .inBlank(inBlank),
    .frameStart(frameStart), .viewAddr(viewAddr), .viewData(viewData));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int satInc(input int v);
    return (v < MAXC) ? v + 1 : v;
  endfunction

  function automatic int expectedView(input int a);
    int region = (a >> 2) & 3;
    int val = 0;
    if (region == 3) return 0;                       // R5
    for (int b = 0; b < 4; b++) begin
      int pick = (region == 0) ? snapFrm[b] : (region == 1) ? snapAct[b] : snapBlk[b];
      if (((a >> 5) & 1) == 1 || (a & 3) == b) val += pick;   // R3 / R2
    end
    return ((a >> 4) & 1) ? ((val >> 8) & 255) : ((val >> 12) & 255);  // R4, R9
  endfunction

  function automatic string tagFor(input int a);
    if (((a >> 2) & 3) == 3) return "R5";
    if ((a >> 5) & 1) return "R3";
    if ((a >> 4) & 1) return "R4";
    if (((a >> 2) & 3) == 0) return "R8";
    return "R2";
  endfunction

  task automatic runCycles(input logic [3:0] acc, input logic blk, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bankAccess = acc;
      inBlank = blk;
      for (int b = 0; b < 4; b++) begin
        if (acc[b]) begin
          liveFrm[b] = satInc(liveFrm[b]);
          if (blk) liveBlk[b] = satInc(liveBlk[b]);
          else     liveAct[b] = satInc(liveAct[b]);
        end
      end
    end
    @(negedge clk);
    bankAccess = '0;
    inBlank = 1'b0;
  endtask

  task automatic frameEdge(input logic [3:0] acc);
    @(negedge clk);
    frameStart = 1'b1;
    bankAccess = acc;
    inBlank = 1'b0;
    for (int b = 0; b < 4; b++) begin
      snapAct[b] = liveAct[b];
      snapBlk[b] = liveBlk[b];
      snapFrm[b] = liveFrm[b];
      liveAct[b] = acc[b] ? 1 : 0;
      liveBlk[b] = 0;
      liveFrm[b] = acc[b] ? 1 : 0;
    end
    @(negedge clk);
    frameStart = 1'b0;
    bankAccess = '0;
  endtask

  task automatic checkAll(input string scen, input string forceTag);
    for (int a = 0; a < 64; a++) begin
      int exp;
      string tag;
      viewAddr = 6'(a);
      #1;
      exp = expectedView(a);
      tag = (forceTag != "") ? forceTag : tagFor(a);
      checkCount++;
      if (viewData !== 8'(exp)) begin
        failCount++;
        $display("FAIL %s %s addr=%0d actual=%0d expected=%0d", tag, scen, a, viewData, exp);
      end
    end
    viewAddr = '0;
  endtask

  task automatic testReset;
    checkAll("reset state", "R1");
  endtask

  task automatic testPatterns;
    runCycles(4'b0001, 1'b0, 600);
    runCycles(4'b0001, 1'b1, 300);
    runCycles(4'b0010, 1'b0, 5000);
    runCycles(4'b0100, 1'b1, 4500);
    runCycles(4'b1111, 1'b0, 100);
    runCycles(4'b1000, 1'b1, 700);
    frameEdge(4'b0000);
    checkAll("mixed banks and regions", "");
  endtask

  task automatic testBoundary;
    runCycles(4'b0011, 1'b1, 40);
    checkAll("snapshot held mid-frame R6", "R6");
    frameEdge(4'b1111);
    runCycles(4'b0001, 1'b0, 255);
    runCycles(4'b0010, 1'b1, 511);
    frameEdge(4'b0000);
    checkAll("access on frame-start cycle R6", "R6");
  endtask

  task automatic testSaturate;
    runCycles(4'b1001, 1'b1, 66000);
    runCycles(4'b0110, 1'b0, 20000);
    frameEdge(4'b0000);
    checkAll("counter saturation R7", "R7");
    frameEdge(4'b0000);
    checkAll("empty frame after clear R6", "R6");
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checkCount, failCount);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 4; b++) begin
      liveAct[b] = 0; liveBlk[b] = 0; liveFrm[b] = 0;
      snapAct[b] = 0; snapBlk[b] = 0; snapFrm[b] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    testReset();
    testPatterns();
    testBoundary();
    testSaturate();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checkCount, failCount);
    $finish;
  end
endmodule